// File: doc/BRIEF.md
# Memory Access Splitter with Atomicity Flag

This block takes one load or store request at a time: a byte address, a length of 1 to 32 bytes, a cacheable attribute and a direction. It cuts the request into one or more beats on an internal data path of `PATH_BYTES` bytes and hands them out one per cycle. Each beat carries its first byte address, a byte-enable mask over the path word, a last marker, the direction, and a flag that says whether the whole request is single-copy atomic.

Two policies decide both the atomicity flag and where the request is cut. The policy is chosen by a static input. The line policy cuts at path-word boundaries and treats power-of-two accesses that stay inside one 64-byte line as atomic. The chunk policy cuts at 8-byte boundaries and treats any access that stays inside one aligned 8-byte chunk as atomic. A separate input grants atomicity to 16-byte aligned 16-byte accesses.

Both sides use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that acceptance until the cycle after the last beat has been taken. A beat is taken on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented beat is held unchanged.

Top module: `mem_access_splitter`

## Requirements
- R1: After reset `req_ready` is 1 and `out_valid` is 0. A request accepted at a clock edge puts its first beat on the outputs right after that edge. `req_ready` stays 0 until the edge where the beat with `out_last`=1 is taken, and returns to 1 right after that edge.
- R2: While `out_valid`=1 and `out_ready`=0, every beat output keeps its value into the next cycle.
- R3: The beats cover the request bytes in ascending order, and each beat stops at the next boundary: 8 bytes when `pol_chunk`=1, `PATH_BYTES` (default 16) when `pol_chunk`=0. `out_addr` is the beat's first byte. Bit i of `out_be` is set exactly for lanes (`out_addr` mod `PATH_BYTES`) through (beat's last byte mod `PATH_BYTES`). `out_last`=1 only on the final beat. `out_store` repeats `req_store` on every beat.
- R4: `out_atomic`, which is the same on every beat of a request, is 1 for any 1-byte access. It is also 1 for a 2-, 4- or 8-byte access whose address is a multiple of its length.
- R5: With `pol_chunk`=0 and `req_cacheable`=1, a 2-, 4- or 8-byte access that lies wholly inside one 64-byte line is atomic, even when unaligned.
- R6: With `pol_chunk`=1 and `req_cacheable`=1, an access of any length from 1 to 8 bytes that lies wholly inside one 8-byte aligned chunk is atomic.
- R7: An access whose first and last bytes lie in different 64-byte lines or different 4 KiB pages is never atomic.
- R8: With `req_cacheable`=0, a 2-byte access that lies inside one 4-byte aligned word is atomic.
- R9: An access longer than 8 bytes is atomic only when `wide_atomic_ok`=1, the length is 16 and the address is 16-byte aligned.
- R10: Every access not covered by R4, R5, R6, R8 or R9 is non-atomic. Examples are a 3-byte access under the line policy and an unaligned uncacheable 4-byte access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pol_chunk | input | 1 | Policy select: 1 = chunk policy, 0 = line policy; sampled when a request is accepted |
| wide_atomic_ok | input | 1 | Allows 16-byte aligned 16-byte accesses to be atomic |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_len_m1 | input | 5 | Length in bytes minus one (0..31) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | 1 = cacheable memory |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_addr | output | ADDR_W | First byte address of the beat |
| out_be | output | PATH_BYTES | Byte enables over the path word |
| out_last | output | 1 | Final beat of the request |
| out_store | output | 1 | Direction of the request |
| out_atomic | output | 1 | Request is single-copy atomic |

## Verification
The assertions assume that a request's last byte does not wrap past the top of the address space. They also assume that `out_ready` is a plain level that the block never has to wait on for correctness. The stimulus keeps every address well below the top of the space, so no request wraps. It holds each offered request steady until it is accepted, and toggles `out_ready` at random so that beats are both held and taken. Addresses are chosen so that requests cross 8-byte, path-word, line and page boundaries under both policies and with both attributes.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
  // 4 KiB page for crossing detection
  localparam int PAGE_LG  = 12;
  // chunk policy granule: 8 bytes
  localparam int CHUNK_LG = 3;
  // request length field width (length minus one)
  localparam int LEN_W    = 5;
endpackage

// File: rtl/msplit_atomicity.sv
module msplit_atomicity
  import msplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_LG = 6
) (
  input  logic [ADDR_W-1:0] first_a,
  input  logic [ADDR_W-1:0] last_a,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cacheable,
  input  logic              chunk_mode,
  input  logic              wide_ok,
  output logic              atomic
);
  logic line_cross, page_cross, in_chunk, in_word;
  logic pow2_small, nat_aligned, single, wide16;

  always_comb begin
    line_cross  = first_a[ADDR_W-1:LINE_LG] != last_a[ADDR_W-1:LINE_LG];
    page_cross  = first_a[ADDR_W-1:PAGE_LG] != last_a[ADDR_W-1:PAGE_LG];
    in_chunk    = first_a[ADDR_W-1:CHUNK_LG] == last_a[ADDR_W-1:CHUNK_LG];
    in_word     = first_a[ADDR_W-1:2] == last_a[ADDR_W-1:2];
    single      = len_m1 == '0;
    pow2_small  = (len_m1 == LEN_W'(1)) || (len_m1 == LEN_W'(3)) || (len_m1 == LEN_W'(7));
    nat_aligned = (first_a[2:0] & len_m1[2:0]) == 3'd0;
    wide16      = wide_ok && (len_m1 == LEN_W'(15)) && (first_a[3:0] == 4'd0);
    atomic = !line_cross && !page_cross &&
             ( single
             || (pow2_small && nat_aligned)
             || (cacheable && !chunk_mode && pow2_small)
             || (cacheable && chunk_mode && in_chunk)
             || (!cacheable && (len_m1 == LEN_W'(1)) && in_word)
             || wide16 );
  end
endmodule

// File: rtl/msplit_beat.sv
module msplit_beat
  import msplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PATH_BYTES = 16   // must be a power of two, at least 8
) (
  input  logic [ADDR_W-1:0]     cur_a,
  input  logic [ADDR_W-1:0]     last_a,
  input  logic                  chunk_mode,
  output logic [ADDR_W-1:0]     beat_end,
  output logic [PATH_BYTES-1:0] be,
  output logic                  is_last
);
  localparam int PATH_LG = $clog2(PATH_BYTES);

  logic [ADDR_W-1:0]  seg_end;
  logic               same_seg;
  logic [PATH_LG-1:0] lo_lane, hi_lane;

  always_comb begin
    if (chunk_mode) begin
      seg_end  = cur_a | ADDR_W'((1 << CHUNK_LG) - 1);
      same_seg = cur_a[ADDR_W-1:CHUNK_LG] == last_a[ADDR_W-1:CHUNK_LG];
    end else begin
      seg_end  = cur_a | ADDR_W'(PATH_BYTES - 1);
      same_seg = cur_a[ADDR_W-1:PATH_LG] == last_a[ADDR_W-1:PATH_LG];
    end
    is_last  = same_seg;
    beat_end = same_seg ? last_a : seg_end;
    lo_lane  = cur_a[PATH_LG-1:0];
    hi_lane  = beat_end[PATH_LG-1:0];
  end

  for (genvar i = 0; i < PATH_BYTES; i++) begin : g_lane
    assign be[i] = (PATH_LG'(i) >= lo_lane) && (PATH_LG'(i) <= hi_lane);
  end
endmodule

// File: rtl/mem_access_splitter.sv
module mem_access_splitter
  import msplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PATH_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pol_chunk,
  input  logic                  wide_atomic_ok,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len_m1,
  input  logic                  req_store,
  input  logic                  req_cacheable,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [PATH_BYTES-1:0] out_be,
  output logic                  out_last,
  output logic                  out_store,
  output logic                  out_atomic
);
  localparam int LINE_LG = $clog2(LINE_BYTES);

  logic              busy_q, store_q, atomic_q, chunk_q;
  logic [ADDR_W-1:0] cur_q, last_q;
  logic [ADDR_W-1:0] req_last, beat_end;
  logic              req_atomic, accept, take;

  assign req_last = req_addr + ADDR_W'(req_len_m1);
  assign accept   = req_valid && req_ready;
  assign take     = out_valid && out_ready;

  msplit_atomicity #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_atom (
    .first_a(req_addr), .last_a(req_last), .len_m1(req_len_m1),
    .cacheable(req_cacheable), .chunk_mode(pol_chunk),
    .wide_ok(wide_atomic_ok), .atomic(req_atomic)
  );

  msplit_beat #(.ADDR_W(ADDR_W), .PATH_BYTES(PATH_BYTES)) u_beat (
    .cur_a(cur_q), .last_a(last_q), .chunk_mode(chunk_q),
    .beat_end(beat_end), .be(out_be), .is_last(out_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      last_q   <= '0;
      store_q  <= 1'b0;
      atomic_q <= 1'b0;
      chunk_q  <= 1'b0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      cur_q    <= req_addr;
      last_q   <= req_last;
      store_q  <= req_store;
      atomic_q <= req_atomic;
      chunk_q  <= pol_chunk;
    end else if (take) begin
      if (out_last) busy_q <= 1'b0;
      else          cur_q  <= beat_end + ADDR_W'(1);
    end
  end

  assign req_ready  = !busy_q;
  assign out_valid  = busy_q;
  assign out_addr   = cur_q;
  assign out_store  = store_q;
  assign out_atomic = atomic_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
      && $stable(out_last) && $stable(out_atomic) && $stable(out_store));

  p_busy_until_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !out_last |=> out_valid && !req_ready);

  p_ready_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && out_last |=> req_ready && !out_valid);

  p_contiguous_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !out_last |=> out_addr == $past(out_addr) + ADDR_W'($countones($past(out_be))));

  p_be_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_be != '0);

  p_chunk_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && chunk_q |-> $countones(out_be) <= 8);

  p_cross_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((req_addr[ADDR_W-1:LINE_LG] != req_last[ADDR_W-1:LINE_LG])
            || (req_addr[ADDR_W-1:PAGE_LG] != req_last[ADDR_W-1:PAGE_LG]))
    |=> !out_atomic);
endmodule

// File: tb/mem_access_splitter_tb_top.sv
module mem_access_splitter_tb_top;
  logic clk = 0, rst_n = 0;
  logic pol_chunk = 0, wide_atomic_ok = 0, req_valid = 0, req_store = 0, req_cacheable = 0;
  logic [31:0] req_addr = 0;
  logic [4:0]  req_len_m1 = 0;
  logic out_ready = 0;
  logic req_ready, out_valid, out_last, out_store, out_atomic;
  logic [31:0] out_addr;
  logic [15:0] out_be;

  always #5 clk = ~clk;

  mem_access_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .pol_chunk(pol_chunk), .wide_atomic_ok(wide_atomic_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .req_store(req_store), .req_cacheable(req_cacheable),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_be(out_be),
    .out_last(out_last), .out_store(out_store), .out_atomic(out_atomic)
  );

  typedef struct { int a; int n; bit st; bit cach; bit chunk; bit w; } req_s;
  typedef struct { int a; logic [15:0] be; bit last; bit atom; bit st; string tag; } beat_s;

  req_s  reqs[$];
  beat_s q[$];
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit ref_atomic(req_s r, output string tag);
    int f = r.a, l = r.a + r.n - 1;
    if (f / 64 != l / 64 || f / 4096 != l / 4096) begin tag = "R7"; return 0; end
    if (r.n == 1) begin tag = "R4"; return 1; end
    if ((r.n == 2 || r.n == 4 || r.n == 8) && (f % r.n == 0)) begin tag = "R4"; return 1; end
    if (r.n > 8) begin tag = "R9"; return r.w && r.n == 16 && f % 16 == 0; end
    if (r.cach && !r.chunk && (r.n == 2 || r.n == 4 || r.n == 8)) begin tag = "R5"; return 1; end
    if (r.cach && r.chunk && f / 8 == l / 8) begin tag = "R6"; return 1; end
    if (!r.cach && r.n == 2 && f / 4 == l / 4) begin tag = "R8"; return 1; end
    tag = "R10"; return 0;
  endfunction

  task automatic push_beats(req_s r);
    int bnd = r.chunk ? 8 : 16;
    int p = r.a, l = r.a + r.n - 1;
    string tag;
    bit at = ref_atomic(r, tag);
    while (p <= l) begin
      beat_s b;
      int e = (p / bnd) * bnd + bnd - 1;
      if (e > l) e = l;
      b.a = p; b.be = '0;
      for (int k = p % 16; k <= e % 16; k++) b.be[k] = 1'b1;
      b.last = (e == l); b.atom = at; b.st = r.st; b.tag = tag;
      q.push_back(b);
      p = e + 1;
    end
  endtask

  task automatic add(int a, int n, bit st, bit cach, bit chunk, bit w);
    req_s r; r.a = a; r.n = n; r.st = st; r.cach = cach; r.chunk = chunk; r.w = w;
    reqs.push_back(r);
  endtask

  initial begin
    bit prev_acc = 0, prev_fire = 0, prev_hold = 0;
    logic [31:0] s_addr; logic [15:0] s_be; logic s_last, s_atom;
    req_s cur;
    // directed corner cases
    add('h1003, 1, 0, 1, 0, 0);   // R4 single byte
    add('h1006, 2, 1, 0, 0, 0);   // R4 aligned 2
    add('h100D, 4, 0, 1, 0, 0);   // R5 unaligned in line, split at 16
    add('h100D, 4, 0, 1, 1, 0);   // R10 chunk policy, crosses 8
    add('h1009, 3, 1, 1, 1, 0);   // R6 odd size in chunk
    add('h1009, 3, 1, 1, 0, 0);   // R10 odd size, line policy
    add('h103C, 8, 0, 1, 0, 0);   // R7 line cross
    add('h0FFE, 4, 1, 1, 1, 0);   // R7 page cross
    add('h1001, 2, 0, 0, 0, 0);   // R8 uncached in word
    add('h1003, 2, 0, 0, 0, 0);   // R10 uncached across word
    add('h1005, 4, 0, 0, 1, 0);   // R10 uncached unaligned 4
    add('h1010, 16, 0, 1, 0, 1);  // R9 wide atomic
    add('h1010, 16, 0, 1, 0, 0);  // R9 no capability
    add('h1008, 16, 1, 1, 1, 1);  // R9 misaligned
    add('h1004, 32, 1, 1, 0, 0);  // R3 long split, line policy
    add('h1004, 32, 0, 1, 1, 1);  // R3 long split, chunk policy
    for (int i = 0; i < 400; i++) begin
      int n = ($urandom % 2 == 0) ? (1 << ($urandom % 6)) : 1 + int'($urandom % 32);
      add('h2000 + int'($urandom % 'h3000), n, 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom));
    end

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    rst_n = 1;

    while (reqs.size() != 0 || q.size() != 0 || prev_acc) begin
      @(negedge clk);
      if (prev_fire) void'(q.pop_front());
      if (prev_acc) begin push_beats(cur); void'(reqs.pop_front()); end
      chk(req_ready == (q.size() == 0), "R1", "req_ready", req_ready, q.size() == 0);
      chk(out_valid == (q.size() != 0), "R1", "out_valid", out_valid, q.size() != 0);
      if (out_valid && q.size() != 0) begin
        chk(out_addr == 32'(q[0].a), "R3", "out_addr", out_addr, q[0].a);
        chk(out_be == q[0].be, "R3", "out_be", out_be, q[0].be);
        chk(out_last == q[0].last, "R3", "out_last", out_last, q[0].last);
        chk(out_store == q[0].st, "R3", "out_store", out_store, q[0].st);
        chk(out_atomic == q[0].atom, q[0].tag, "out_atomic", out_atomic, q[0].atom);
      end
      if (prev_hold)
        chk(out_valid && out_addr == s_addr && out_be == s_be && out_last == s_last
            && out_atomic == s_atom, "R2", "held beat addr", out_addr, s_addr);
      out_ready = ($urandom % 4) != 0;
      if (reqs.size() != 0) begin
        cur = reqs[0];
        req_valid = 1; req_addr = cur.a; req_len_m1 = 5'(cur.n - 1);
        req_store = cur.st; req_cacheable = cur.cach; pol_chunk = cur.chunk;
        wide_atomic_ok = cur.w;
      end else req_valid = 0;
      prev_acc  = req_valid && req_ready;
      prev_fire = out_valid && out_ready;
      prev_hold = out_valid && !out_ready;
      s_addr = out_addr; s_be = out_be; s_last = out_last; s_atom = out_atomic;
    end
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && out_valid == 1'b0, "R1", "final idle", req_ready, 1);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule